// File: doc/BRIEF.md
# NAND Command and Address Sequence Generator

This block turns one 64-bit command word into the command-latch and address-latch byte cycles of a raw NAND flash bus. A start pulse hands over the word. The block decodes a 6-bit instruction type and an alternate-opcode bit into a fixed series of cycles. The series has an optional leading opcode, zero to six address bytes and an optional trailing opcode. Each cycle is a write-enable strobe whose low and high lengths are set by inputs. After the last cycle the block holds the bus idle for a wait chosen by the instruction, then pulses `done_o`.

The block also drives one active-low chip enable per chip. A sequence asserts the chip enable of its chip from the cycle after start until after `done_o`. A hold bit in the command word keeps that chip enable asserted into the next sequence. A command word with an unknown instruction type, an address count outside the allowed range for its type, or a chip number that does not exist ends at once with `err_o`. In that case the bus does not move and the chip enables do not change. The data phase, error correction and double-data-rate signalling belong to other blocks.

Top module: `nand_seq_gen`

## Requirements
- R1: During and after reset, `we_n_o`=1, `cle_o`=0, `ale_o`=0, `dq_o`=0, every `ce_n_o` bit is 1, and `done_o` and `err_o` are 0.
- R2: Each bus cycle holds `we_n_o` low for `t_we_lo_i` clocks and then high for `t_we_hi_i` clocks, with 0 treated as 1. `dq_o`, `cle_o` and `ale_o` are constant through the whole cycle. Opcode cycles raise `cle_o` and address cycles raise `ale_o`, never both at once.
- R3: Address bytes are taken from `cmd_i[23:16]` (byte 0) upward in 8-bit steps to `cmd_i[63:56]` (byte 5), and byte 0 is sent first. The count field `cmd_i[13:11]` holds N, which means N+1 address cycles.
- R4: Type 0 (`cmd_i[5:0]`) sends the single opcode `cmd_i[23:16]`. Type 1 sends N+1 address bytes, with N from 0 to 5. For these two types only, `cmd_i[6]`=1 selects the `t_wb_i` wait and 0 selects no wait.
- R5: Type 3 sends 00h, N+1 address bytes and 30h. Type 6 sends 60h, N+1 address bytes and D0h. Type 3 allows N from 3 to 5, type 6 allows N from 1 to 3, and both use the `t_wb_i` wait.
- R6: Type 4 sends 80h, or 81h when `cmd_i[7]`=1, then N+1 address bytes with N from 3 to 5, then the `t_adl_i` wait.
- R7: Type 5 sends FFh with the `t_feat_i` wait. Type 7 sends 70h, or with `cmd_i[7]`=1 it sends F1h when `cmd_i[11]`=0 and F2h when `cmd_i[11]`=1. Type 7 uses the `t_whr_i` wait.
- R8: Types 21, 23, 24 and 27 each send one opcode and then address byte 0. The opcode and wait are E1h with `t_vdly_i` for type 21, EFh with `t_adl_i` for type 23, EEh with `t_wb_i` for type 24, and 90h with `t_whr_i` for type 27.
- R9: Type 12 sends 05h, then address bytes, then E0h, then the `t_ccs_i` wait. The address part is exactly two bytes when `cmd_i[7]`=0, and N+1 bytes with N from 3 to 5 when `cmd_i[7]`=1.
- R10: `done_o` is a one-clock pulse. It comes exactly `t_we_hi_i` (minimum 1) plus the selected wait clocks after the sample in which `we_n_o` last rose.
- R11: The chip selected by `cmd_i[10:8]` has its `ce_n_o` bit low from the first clock after an accepted start through the `done_o` clock, and every other bit is high. If `cmd_i[15]`=0, all bits return high on the clock after `done_o`.
- R12: With `cmd_i[15]`=1, the chip enable stays low after `done_o` until a later sequence ends with the hold clear. A sequence that starts on a different chip releases the held chip as it asserts its own.
- R13: An unsupported type, an out-of-range N, or a chip number of at least NUM_CHIPS gives `done_o` and `err_o` together in the first clock after start. In that case there is no write-enable strobe and `ce_n_o` does not change.
- R14: A start pulse while a sequence is in progress is ignored. The command word is captured at start, so later changes to `cmd_i` do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cmd_i | input | 64 | Command word |
| t_we_lo_i | input | CNT_W | Write-enable low clocks per bus cycle |
| t_we_hi_i | input | CNT_W | Write-enable high clocks per bus cycle |
| t_wb_i | input | CNT_W | Busy-settle wait clocks |
| t_adl_i | input | CNT_W | Address-to-data wait clocks |
| t_whr_i | input | CNT_W | Command-to-read-data wait clocks |
| t_ccs_i | input | CNT_W | Column-change wait clocks |
| t_feat_i | input | CNT_W | Reset/feature wait clocks |
| t_vdly_i | input | CNT_W | Volume-select wait clocks |
| dq_o | output | 8 | Bus byte |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write enable, active low |
| ce_n_o | output | NUM_CHIPS | Chip enables, active low, one per chip |
| done_o | output | 1 | Sequence-complete pulse |
| err_o | output | 1 | Rejected command, valid with done_o |

## Verification
The bench builds the block with NUM_CHIPS=4 and CNT_W=8. This makes chip codes 4 to 7 legal encodings that the block must reject, so the out-of-range chip path is reached by both directed and random commands. The wait inputs are set to distinct small values, so each done timing shows which wait the decoder picked. Strobe lengths of 0 and 1 reach the clamp and the shortest bus cycles, and a zero wait reaches the path that goes straight from the last strobe to completion.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    W_NONE, W_WB, W_ADL, W_WHR, W_CCS, W_FEAT, W_VDLY
  } wsel_e;

  typedef enum logic [1:0] {
    SL_PRE, SL_ADDR, SL_POST
  } slot_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_WAIT, S_DONE
  } st_e;

  typedef struct packed {
    logic       ok;
    logic       pre_en;
    logic [7:0] pre_op;
    logic [2:0] n_addr;
    logic       post_en;
    logic [7:0] post_op;
    wsel_e      wsel;
  } plan_t;

  localparam logic [5:0] IT_CMD    = 6'd0;
  localparam logic [5:0] IT_ADDR   = 6'd1;
  localparam logic [5:0] IT_READ   = 6'd3;
  localparam logic [5:0] IT_WRITE  = 6'd4;
  localparam logic [5:0] IT_RESET  = 6'd5;
  localparam logic [5:0] IT_ERASE  = 6'd6;
  localparam logic [5:0] IT_STAT   = 6'd7;
  localparam logic [5:0] IT_COLRD  = 6'd12;
  localparam logic [5:0] IT_VOLSEL = 6'd21;
  localparam logic [5:0] IT_SETF   = 6'd23;
  localparam logic [5:0] IT_GETF   = 6'd24;
  localparam logic [5:0] IT_RDID   = 6'd27;

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
  import nseq_pkg::*;
(
  input  logic [5:0] ity_i,
  input  logic       twb_i,
  input  logic       alt_i,
  input  logic [2:0] nf_i,
  input  logic [7:0] op0_i,
  output plan_t      plan_o
);

  logic [2:0] n1;

  function automatic logic in_rng(input logic [2:0] v, input logic [2:0] lo, input logic [2:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  assign n1 = nf_i + 3'd1;

  always_comb begin
    plan_o      = '0;
    plan_o.wsel = W_NONE;
    unique case (ity_i)
      IT_CMD: begin
        plan_o.ok     = 1'b1;
        plan_o.pre_en = 1'b1;
        plan_o.pre_op = op0_i;
        plan_o.wsel   = twb_i ? W_WB : W_NONE;
      end
      IT_ADDR: begin
        plan_o.ok     = in_rng(nf_i, 3'd0, 3'd5);
        plan_o.n_addr = n1;
        plan_o.wsel   = twb_i ? W_WB : W_NONE;
      end
      IT_READ: begin
        plan_o.ok      = in_rng(nf_i, 3'd3, 3'd5);
        plan_o.pre_en  = 1'b1;
        plan_o.pre_op  = 8'h00;
        plan_o.n_addr  = n1;
        plan_o.post_en = 1'b1;
        plan_o.post_op = 8'h30;
        plan_o.wsel    = W_WB;
      end
      IT_WRITE: begin
        plan_o.ok     = in_rng(nf_i, 3'd3, 3'd5);
        plan_o.pre_en = 1'b1;
        plan_o.pre_op = alt_i ? 8'h81 : 8'h80;
        plan_o.n_addr = n1;
        plan_o.wsel   = W_ADL;
      end
      IT_RESET: begin
        plan_o.ok     = 1'b1;
        plan_o.pre_en = 1'b1;
        plan_o.pre_op = 8'hFF;
        plan_o.wsel   = W_FEAT;
      end
      IT_ERASE: begin
        plan_o.ok      = in_rng(nf_i, 3'd1, 3'd3);
        plan_o.pre_en  = 1'b1;
        plan_o.pre_op  = 8'h60;
        plan_o.n_addr  = n1;
        plan_o.post_en = 1'b1;
        plan_o.post_op = 8'hD0;
        plan_o.wsel    = W_WB;
      end
      IT_STAT: begin
        plan_o.ok     = 1'b1;
        plan_o.pre_en = 1'b1;
        plan_o.pre_op = !alt_i ? 8'h70 : (nf_i[0] ? 8'hF2 : 8'hF1);
        plan_o.wsel   = W_WHR;
      end
      IT_COLRD: begin
        plan_o.ok      = alt_i ? in_rng(nf_i, 3'd3, 3'd5) : 1'b1;
        plan_o.pre_en  = 1'b1;
        plan_o.pre_op  = 8'h05;
        plan_o.n_addr  = alt_i ? n1 : 3'd2;
        plan_o.post_en = 1'b1;
        plan_o.post_op = 8'hE0;
        plan_o.wsel    = W_CCS;
      end
      IT_VOLSEL, IT_SETF, IT_GETF, IT_RDID: begin
        plan_o.ok     = 1'b1;
        plan_o.pre_en = 1'b1;
        plan_o.n_addr = 3'd1;
        unique case (ity_i)
          IT_VOLSEL: begin plan_o.pre_op = 8'hE1; plan_o.wsel = W_VDLY; end
          IT_SETF:   begin plan_o.pre_op = 8'hEF; plan_o.wsel = W_ADL;  end
          IT_GETF:   begin plan_o.pre_op = 8'hEE; plan_o.wsel = W_WB;   end
          default:   begin plan_o.pre_op = 8'h90; plan_o.wsel = W_WHR;  end
        endcase
      end
      default: plan_o.ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/nseq_timer.sv
module nseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2: an idle counter stays at its floor until reloaded
  a_r2_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/nseq_ce_ctrl.sv
module nseq_ce_ctrl #(
  parameter int NUM_CHIPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 claim_i,
  input  logic [2:0]           chip_i,
  input  logic                 hold_i,
  input  logic                 finish_i,
  output logic [NUM_CHIPS-1:0] ce_n_o
);

  logic       act_q, act_d;
  logic       hold_q;
  logic [2:0] chip_q;

  always_comb begin
    act_d = act_q;
    if (claim_i)                 act_d = 1'b1;
    else if (finish_i && !hold_q) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hold_q <= 1'b0;
      chip_q <= '0;
    end else begin
      act_q <= act_d;
      if (claim_i) begin
        hold_q <= hold_i;
        chip_q <= chip_i;
      end
    end
  end

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_ce
    assign ce_n_o[i] = ~(act_q && (chip_q == 3'(i)));
  end

  // R11: never more than one chip selected
  a_r11_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n_o));

  // R12: a held chip enable survives the end of its sequence
  a_r12_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && hold_q) |=> $stable(ce_n_o));

endmodule

// File: rtl/nand_seq_gen.sv
module nand_seq_gen
  import nseq_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [63:0]          cmd_i,
  input  logic [CNT_W-1:0]     t_we_lo_i,
  input  logic [CNT_W-1:0]     t_we_hi_i,
  input  logic [CNT_W-1:0]     t_wb_i,
  input  logic [CNT_W-1:0]     t_adl_i,
  input  logic [CNT_W-1:0]     t_whr_i,
  input  logic [CNT_W-1:0]     t_ccs_i,
  input  logic [CNT_W-1:0]     t_feat_i,
  input  logic [CNT_W-1:0]     t_vdly_i,
  output logic [7:0]           dq_o,
  output logic                 cle_o,
  output logic                 ale_o,
  output logic                 we_n_o,
  output logic [NUM_CHIPS-1:0] ce_n_o,
  output logic                 done_o,
  output logic                 err_o
);

  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  plan_t plan;
  logic  chip_ok, accept, acc_ok;
  logic  unused_bits;

  nseq_decode u_dec (
    .ity_i  (cmd_i[5:0]),
    .twb_i  (cmd_i[6]),
    .alt_i  (cmd_i[7]),
    .nf_i   (cmd_i[13:11]),
    .op0_i  (cmd_i[23:16]),
    .plan_o (plan)
  );

  assign unused_bits = cmd_i[14];
  assign chip_ok = (32'(cmd_i[10:8]) < NUM_CHIPS);

  st_e               st_q, st_d;
  slot_e             slot_q, slot_d;
  logic [2:0]        aidx_q, aidx_d;
  logic [7:0]        pre_op_q, post_op_q;
  logic [2:0]        n_addr_q;
  logic              post_en_q;
  wsel_e             wsel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;

  assign accept = (st_q == S_IDLE) && start_i;
  assign acc_ok = accept && plan.ok && chip_ok;

  // timing selection
  logic [CNT_W-1:0] wait_len, lo_m1, hi_m1, wait_m1;
  always_comb begin
    unique case (wsel_q)
      W_WB:    wait_len = t_wb_i;
      W_ADL:   wait_len = t_adl_i;
      W_WHR:   wait_len = t_whr_i;
      W_CCS:   wait_len = t_ccs_i;
      W_FEAT:  wait_len = t_feat_i;
      W_VDLY:  wait_len = t_vdly_i;
      default: wait_len = '0;
    endcase
  end
  assign lo_m1   = (t_we_lo_i == '0) ? '0 : t_we_lo_i - CNT_W'(1);
  assign hi_m1   = (t_we_hi_i == '0) ? '0 : t_we_hi_i - CNT_W'(1);
  assign wait_m1 = wait_len - CNT_W'(1);

  logic             tm_load, tm_zero;
  logic [CNT_W-1:0] tm_val;

  nseq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (tm_load),
    .val_i  (tm_val),
    .zero_o (tm_zero)
  );

  // slot successor
  slot_e      nxt_slot;
  logic [2:0] nxt_idx;
  logic       last_slot;
  always_comb begin
    nxt_slot  = slot_q;
    nxt_idx   = aidx_q;
    last_slot = 1'b0;
    unique case (slot_q)
      SL_PRE: begin
        if (n_addr_q != 3'd0) begin nxt_slot = SL_ADDR; nxt_idx = 3'd0; end
        else if (post_en_q)         nxt_slot = SL_POST;
        else                        last_slot = 1'b1;
      end
      SL_ADDR: begin
        if ((aidx_q + 3'd1) < n_addr_q) nxt_idx = aidx_q + 3'd1;
        else if (post_en_q)             nxt_slot = SL_POST;
        else                            last_slot = 1'b1;
      end
      default: last_slot = 1'b1;
    endcase
  end

  // next state
  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    aidx_d  = aidx_q;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        if (acc_ok) begin
          st_d    = S_LO;
          slot_d  = plan.pre_en ? SL_PRE : SL_ADDR;
          aidx_d  = 3'd0;
          tm_load = 1'b1;
          tm_val  = lo_m1;
        end else begin
          st_d = S_DONE;
        end
      end
      S_LO: if (tm_zero) begin
        st_d    = S_HI;
        tm_load = 1'b1;
        tm_val  = hi_m1;
      end
      S_HI: if (tm_zero) begin
        if (!last_slot) begin
          st_d    = S_LO;
          slot_d  = nxt_slot;
          aidx_d  = nxt_idx;
          tm_load = 1'b1;
          tm_val  = lo_m1;
        end else if (wait_len == '0) begin
          st_d = S_DONE;
        end else begin
          st_d    = S_WAIT;
          tm_load = 1'b1;
          tm_val  = wait_m1;
        end
      end
      S_WAIT: if (tm_zero) st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q      <= S_IDLE;
      slot_q    <= SL_PRE;
      aidx_q    <= '0;
      pre_op_q  <= '0;
      post_op_q <= '0;
      n_addr_q  <= '0;
      post_en_q <= 1'b0;
      wsel_q    <= W_NONE;
      addr_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      aidx_q <= aidx_d;
      if (accept) begin
        pre_op_q  <= plan.pre_op;
        post_op_q <= plan.post_op;
        n_addr_q  <= plan.n_addr;
        post_en_q <= plan.post_en;
        wsel_q    <= plan.wsel;
        addr_q    <= cmd_i[63:16];
        err_q     <= !(plan.ok && chip_ok);
      end
    end
  end

  // chip enables
  nseq_ce_ctrl #(.NUM_CHIPS(NUM_CHIPS)) u_ce (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .claim_i  (acc_ok),
    .chip_i   (cmd_i[10:8]),
    .hold_i   (cmd_i[15]),
    .finish_i ((st_q == S_DONE) && !err_q),
    .ce_n_o   (ce_n_o)
  );

  // bus outputs
  logic [7:0] addr_byte, cur_byte;
  logic       bus_on;
  always_comb begin
    addr_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (aidx_q == 3'(i)) addr_byte = addr_q[i*8 +: 8];
  end
  always_comb begin
    unique case (slot_q)
      SL_PRE:  cur_byte = pre_op_q;
      SL_POST: cur_byte = post_op_q;
      default: cur_byte = addr_byte;
    endcase
  end

  assign bus_on = (st_q == S_LO) || (st_q == S_HI);
  assign we_n_o = (st_q != S_LO);
  assign cle_o  = bus_on && (slot_q != SL_ADDR);
  assign ale_o  = bus_on && (slot_q == SL_ADDR);
  assign dq_o   = bus_on ? cur_byte : 8'h00;
  assign done_o = (st_q == S_DONE);
  assign err_o  = done_o && err_q;

  // R2: byte and latch strobe steady across the write-enable rising edge
  a_r2_byte_steady: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(we_n_o) |-> ($stable(dq_o) && $stable(ale_o) && (cle_o || ale_o)));

  // R2: command and address latch never together
  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cle_o && ale_o));

  // R10: completion is a single-clock pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R13: a rejected command finishes in the next clock without a strobe
  a_r13_reject_fast: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q == S_IDLE) && start_i && !(plan.ok && chip_ok)) |=> (done_o && err_o && we_n_o));

  // R14: captured command untouched while busy
  a_r14_capture_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q != S_IDLE) |=> $stable(addr_q));

endmodule

// File: tb/nand_seq_gen_tb.sv
module nand_seq_gen_tb;

  localparam int NCH = 4;
  localparam int CW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [63:0]   cmd_i = '0;
  logic [CW-1:0] t_lo = 8'd2, t_hi = 8'd1;
  logic [CW-1:0] t_wb = 8'd3, t_adl = 8'd5, t_whr = 8'd7, t_ccs = 8'd9, t_feat = 8'd11, t_vdly = 8'd13;
  logic [7:0]    dq_o;
  logic          cle_o, ale_o, we_n_o, done_o, err_o;
  logic [NCH-1:0] ce_n_o;

  always #4 clk = ~clk;  // 125 MHz

  nand_seq_gen #(.NUM_CHIPS(NCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .t_we_lo_i(t_lo), .t_we_hi_i(t_hi), .t_wb_i(t_wb), .t_adl_i(t_adl),
    .t_whr_i(t_whr), .t_ccs_i(t_ccs), .t_feat_i(t_feat), .t_vdly_i(t_vdly),
    .dq_o(dq_o), .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o),
    .ce_n_o(ce_n_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int         exp_n, exp_wait;
  bit         exp_err;
  string      exp_tag;
  logic [7:0] exp_b [16];
  bit         exp_a [16];
  bit         held_act = 0;
  int         held_chip = 0;

  task automatic push(input logic [7:0] b, input bit a);
    exp_b[exp_n] = b; exp_a[exp_n] = a; exp_n++;
  endtask

  task automatic push_addr(input logic [63:0] c, input int k);
    for (int i = 0; i < k; i++) push(c[16+8*i +: 8], 1'b1);
  endtask

  task automatic model(input logic [63:0] c);
    int ty, nf; bit alt, tw, bad;
    ty = int'(c[5:0]); nf = int'(c[13:11]); alt = c[7]; tw = c[6];
    exp_n = 0; exp_wait = 0; bad = 0; exp_tag = "R4";
    case (ty)
      0:  begin push(c[23:16], 0); exp_wait = tw ? int'(t_wb) : 0; end
      1:  begin if (nf > 5) bad = 1; else push_addr(c, nf+1); exp_wait = tw ? int'(t_wb) : 0; end
      3:  begin exp_tag = "R5"; if (nf < 3 || nf > 5) bad = 1;
                push(8'h00, 0); push_addr(c, nf+1); push(8'h30, 0); exp_wait = int'(t_wb); end
      4:  begin exp_tag = "R6"; if (nf < 3 || nf > 5) bad = 1;
                push(alt ? 8'h81 : 8'h80, 0); push_addr(c, nf+1); exp_wait = int'(t_adl); end
      5:  begin exp_tag = "R7"; push(8'hFF, 0); exp_wait = int'(t_feat); end
      6:  begin exp_tag = "R5"; if (nf < 1 || nf > 3) bad = 1;
                push(8'h60, 0); push_addr(c, nf+1); push(8'hD0, 0); exp_wait = int'(t_wb); end
      7:  begin exp_tag = "R7"; push(!alt ? 8'h70 : (c[11] ? 8'hF2 : 8'hF1), 0); exp_wait = int'(t_whr); end
      12: begin exp_tag = "R9"; if (alt && (nf < 3 || nf > 5)) bad = 1;
                push(8'h05, 0); push_addr(c, alt ? nf+1 : 2); push(8'hE0, 0); exp_wait = int'(t_ccs); end
      21: begin exp_tag = "R8"; push(8'hE1, 0); push_addr(c, 1); exp_wait = int'(t_vdly); end
      23: begin exp_tag = "R8"; push(8'hEF, 0); push_addr(c, 1); exp_wait = int'(t_adl); end
      24: begin exp_tag = "R8"; push(8'hEE, 0); push_addr(c, 1); exp_wait = int'(t_wb); end
      27: begin exp_tag = "R8"; push(8'h90, 0); push_addr(c, 1); exp_wait = int'(t_whr); end
      default: bad = 1;
    endcase
    if (int'(c[10:8]) >= NCH) bad = 1;
    exp_err = bad;
    if (bad) begin exp_n = 0; exp_tag = "R13"; end
  endtask

  // bus monitor state
  logic [7:0] cap_b [16];
  bit         cap_a [16], cap_c [16];
  int         nb, lo_run, hi_run, lo_eff, hi_eff;
  bit         prev_we, tim_bad;
  longint     tim_act, tim_exp;
  logic [7:0] cur_b;
  bit         cur_a, cur_c;

  task automatic tim_fail(input longint a, input longint e);
    if (!tim_bad) begin tim_bad = 1; tim_act = a; tim_exp = e; end
  endtask

  task automatic sample();
    if (!we_n_o) begin
      if (prev_we) begin
        if (nb > 0 && hi_run != hi_eff) tim_fail(hi_run, hi_eff);
        lo_run = 1; cur_b = dq_o; cur_a = ale_o; cur_c = cle_o;
      end else begin
        lo_run++;
        if (dq_o !== cur_b || ale_o !== cur_a || cle_o !== cur_c) tim_fail(dq_o, cur_b);
      end
    end else begin
      if (!prev_we) begin
        if (lo_run != lo_eff) tim_fail(lo_run, lo_eff);
        if (dq_o !== cur_b) tim_fail(dq_o, cur_b);
        if (nb < 16) begin cap_b[nb] = dq_o; cap_a[nb] = ale_o; cap_c[nb] = cle_o; end
        nb++; hi_run = 1;
      end else hi_run++;
    end
    prev_we = we_n_o;
  endtask

  task automatic run_seq(input logic [63:0] c, input bit poke);
    logic [NCH-1:0] ce_pre, ce_busy, ce_post;
    int  samples; bit got, err_at, ce_bad; logic [NCH-1:0] ce_seen;
    model(c);
    lo_eff = (t_lo == 0) ? 1 : int'(t_lo);
    hi_eff = (t_hi == 0) ? 1 : int'(t_hi);
    ce_pre = held_act ? ~(NCH'(1) << held_chip) : '1;
    if (exp_err) begin
      ce_busy = ce_pre; ce_post = ce_pre;
    end else begin
      ce_busy = ~(NCH'(1) << int'(c[10:8]));
      ce_post = c[15] ? ce_busy : '1;
      held_act = c[15]; held_chip = int'(c[10:8]);
    end
    nb = 0; lo_run = 0; hi_run = 0; prev_we = 1; tim_bad = 0; tim_act = 0; tim_exp = 0;
    cur_b = '0; cur_a = 0; cur_c = 0; ce_bad = 0; ce_seen = '1; err_at = 0;
    @(negedge clk); cmd_i = c; start_i = 1'b1;
    samples = 0; got = 0;
    while (!got && samples < 3000) begin
      @(negedge clk);
      if (poke && samples == 3) begin cmd_i = c ^ 64'hA5A5_A5A5_A5A5_0300; start_i = 1'b1; end
      else start_i = 1'b0;
      samples++;
      sample();
      if (ce_n_o !== ce_busy && !ce_bad) begin ce_bad = 1; ce_seen = ce_n_o; end
      if (done_o) begin got = 1; err_at = err_o; end
    end
    start_i = 1'b0;
    chk(got, "R10 done seen", got, 1);
    chk(err_at == exp_err, {exp_tag, " err flag"}, err_at, exp_err);
    chk(!ce_bad, exp_err ? "R13 ce unchanged" : "R11 ce during sequence", ce_seen, ce_busy);
    if (exp_err) begin
      chk(samples == 1, "R13 latency", samples, 1);
      chk(nb == 0, "R13 no strobe", nb, 0);
    end else begin
      chk(nb == exp_n, poke ? "R14 cycle count" : {exp_tag, " cycle count"}, nb, exp_n);
      for (int i = 0; i < exp_n && i < nb; i++)
        chk(cap_b[i] === exp_b[i] && cap_a[i] == exp_a[i] && cap_c[i] == !exp_a[i],
            exp_a[i] ? "R3 address byte" : {exp_tag, " opcode byte"},
            {cap_a[i], cap_b[i]}, {exp_a[i], exp_b[i]});
      chk(!tim_bad, "R2 strobe timing/stability", tim_act, tim_exp);
      chk(hi_run == hi_eff + exp_wait + 1, "R10 wait before done", hi_run, hi_eff + exp_wait + 1);
    end
    @(negedge clk);
    chk(!done_o, "R10 pulse width", done_o, 0);
    chk(ce_n_o === ce_post, c[15] ? "R12 ce after done" : "R11 ce after done", ce_n_o, ce_post);
  endtask

  function automatic logic [63:0] mk(input int ty, input int nf, input int chip, input bit alt,
                                     input bit tw, input bit hold, input logic [47:0] a);
    return {a, hold, 1'b0, 3'(nf), 3'(chip), alt, tw, 6'(ty)};
  endfunction

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [47:0] AB = 48'h6655_4433_2211;
  int types [15] = '{0, 1, 3, 4, 5, 6, 7, 12, 21, 23, 24, 27, 2, 8, 63};

  initial begin : main
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(we_n_o && !cle_o && !ale_o && dq_o == 0 && ce_n_o == '1 && !done_o && !err_o,
        "R1 in reset", {we_n_o, cle_o, ale_o, done_o, err_o}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(we_n_o && !cle_o && !ale_o && dq_o == 0 && ce_n_o == '1 && !done_o && !err_o,
        "R1 after reset", {we_n_o, cle_o, ale_o, done_o, err_o}, 5'b10000);

    run_seq(mk(3, 5, 0, 1, 0, 0, AB), 0);             // R5 read, six address bytes
    run_seq(mk(6, 0, 0, 0, 0, 0, AB), 0);             // R13 erase count too low
    run_seq(mk(6, 3, 1, 0, 0, 0, AB), 0);             // R5 erase
    run_seq(mk(4, 3, 2, 1, 0, 0, AB), 0);             // R6 write alternate
    run_seq(mk(4, 2, 2, 0, 0, 0, AB), 0);             // R13 write count too low
    t_wb = 8'd0;
    run_seq(mk(0, 0, 0, 0, 1, 0, 48'h0000_0000_00A5), 0); // R4 zero wait
    t_wb = 8'd3;
    run_seq(mk(0, 0, 3, 0, 1, 0, 48'h0000_0000_003C), 0); // R4 with wait
    run_seq(mk(1, 5, 0, 0, 0, 0, AB), 0);             // R4 address only
    run_seq(mk(1, 6, 0, 0, 0, 0, AB), 0);             // R13 address count 7
    run_seq(mk(7, 1, 0, 1, 0, 0, AB), 0);             // R7 F2h
    run_seq(mk(7, 0, 0, 1, 0, 0, AB), 0);             // R7 F1h
    run_seq(mk(7, 1, 0, 0, 0, 0, AB), 0);             // R7 70h
    run_seq(mk(5, 0, 1, 0, 0, 0, AB), 0);             // R7 reset
    run_seq(mk(12, 5, 0, 0, 0, 0, AB), 0);            // R9 two bytes fixed
    run_seq(mk(12, 4, 0, 1, 0, 0, AB), 0);            // R9 alternate, five bytes
    run_seq(mk(12, 2, 0, 1, 0, 0, AB), 0);            // R13 alternate count too low
    run_seq(mk(21, 0, 0, 0, 0, 0, AB), 0);            // R8
    run_seq(mk(23, 0, 0, 0, 0, 0, AB), 0);            // R8
    run_seq(mk(24, 0, 0, 0, 0, 0, AB), 0);            // R8
    run_seq(mk(27, 0, 0, 0, 0, 0, AB), 0);            // R8
    run_seq(mk(2, 0, 0, 0, 0, 0, AB), 0);             // R13 unsupported type
    run_seq(mk(5, 0, 5, 0, 0, 0, AB), 0);             // R13 chip out of range
    run_seq(mk(5, 0, 1, 0, 0, 1, AB), 0);             // R12 hold on chip 1
    repeat (5) @(negedge clk);
    chk(ce_n_o === 4'b1101, "R12 held while idle", ce_n_o, 4'b1101);
    run_seq(mk(63, 0, 0, 0, 0, 0, AB), 0);            // R13 reject keeps held chip
    run_seq(mk(23, 0, 2, 0, 0, 1, AB), 0);            // R12 switch to chip 2, held
    run_seq(mk(27, 0, 2, 0, 0, 0, AB), 0);            // R12 release by clear hold
    run_seq(mk(3, 4, 1, 0, 0, 0, AB), 1);             // R14 start while busy
    t_lo = 8'd0; t_hi = 8'd0;
    run_seq(mk(6, 2, 3, 0, 0, 0, AB), 0);             // R2 zero counts act as one
    t_lo = 8'd3; t_hi = 8'd2;
    run_seq(mk(4, 5, 0, 0, 0, 0, AB), 0);             // R2 longer strobe

    for (int it = 0; it < 160; it++) begin
      logic [63:0] c; int chip;
      c = {$urandom, $urandom};
      chip = ($urandom_range(0, 9) == 0) ? int'($urandom_range(4, 7)) : int'($urandom_range(0, 3));
      c[5:0]   = 6'(types[$urandom_range(0, 14)]);
      c[10:8]  = 3'(chip);
      c[15]    = ($urandom_range(0, 3) == 0);
      c[14]    = 1'b0;
      if (it % 8 == 0) begin
        t_lo = 8'($urandom_range(0, 3)); t_hi = 8'($urandom_range(0, 3));
        t_wb = 8'($urandom_range(0, 6)); t_adl = 8'($urandom_range(0, 6));
        t_whr = 8'($urandom_range(0, 6)); t_ccs = 8'($urandom_range(0, 6));
        t_feat = 8'($urandom_range(0, 6)); t_vdly = 8'($urandom_range(0, 6));
      end
      run_seq(c, ($urandom_range(0, 5) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule